// File: doc/BRIEF.md
# Switch-on-Event Thread Switch Controller

This block decides which of a small set of hardware thread contexts owns an in-order pipeline. The running thread keeps the pipeline until a switch event arrives: a cache miss, a synchronization fault, an explicit switch hint, a low-power request, expiry of a fairness timer, or memory data coming back for a thread that is parked on a miss. On a switch the controller raises a one-cycle flush pulse. It stores the running thread's current PC in that thread's context slot. It holds a busy indication for a fixed number of drain cycles and then redirects fetch to the PC saved for the chosen context.

The next context is picked in round-robin order after the current one. A context is eligible only when its external ready bit is set and it is not parked on a miss. A data-return event targets the returning thread directly. When nothing else is eligible, a thread that was not blocked simply keeps running. If the current thread has just blocked, the pipeline drains and sits idle until some context becomes eligible, and that context then resumes with no further flush.

Top module: `tsw_ctrl`

## Requirements
- R1: After reset, context 0 is active and `flush`, `busy`, `idle` and `redir_valid` are all low. Context slot i holds the PC value i*4096.
- R2: A switch raises `flush` for exactly one cycle, one clock after the triggering event. `busy` is high for FLUSH_CYC cycles, starting with the flush cycle. In the cycle after the last busy cycle, `redir_valid` pulses and `active_id` shows the new context.
- R3: A cache miss or synchronization fault marks the running context as blocked. A blocked context is never chosen as a target until a data return names it on `ev_ret_id`.
- R4: A data return names a context on `ev_ret_id`. If that context is eligible and is not the running one, the controller switches directly to it.
- R5: When TIMEOUT cycles pass in the running state without any switch event, a switch is forced. The old context is left eligible.
- R6: A switch hint or a low-power request switches to the next eligible context and leaves the old context eligible.
- R7: When several events are present together, only the one with the highest priority acts. The order from highest to lowest is synchronization fault, cache miss, switch hint, low-power request, timeout, data return.
- R8: Events that arrive while `busy` is high are held. They are acted on in the first running cycle after the redirect, and they never start a second flush inside a switch.
- R9: If no other context is eligible, a non-blocking event keeps the current thread running without a flush. A blocking event flushes and then raises `idle`. Once some context becomes eligible, the controller leaves idle with a redirect and no flush.
- R10: On each switch, the `cur_pc` value present in the decision cycle is stored for the departing context. A later redirect to that context puts out exactly that value on `redir_pc`.
- R11: A context whose `ready_mask` bit is low is skipped by round-robin selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_mask | input | NCTX | Per-context ready bits supplied by software/OS logic |
| ev_miss | input | 1 | Running thread took a cache miss |
| ev_sync | input | 1 | Running thread hit a synchronization fault |
| ev_hint | input | 1 | Switch-hint instruction retired |
| ev_lpwr | input | 1 | Request to enter low-power mode |
| ev_ret | input | 1 | Memory data returned for a parked context |
| ev_ret_id | input | IDW | Context that the data return belongs to |
| cur_pc | input | PC_W | PC of the running thread to save on a switch |
| flush | output | 1 | One-cycle pipeline flush pulse |
| busy | output | 1 | Switch in progress, no issue allowed |
| idle | output | 1 | No eligible context, pipeline idles |
| active_id | output | IDW | Context that currently owns the pipeline |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_pc | output | PC_W | Redirect target PC, valid with `redir_valid` |

## Verification
The assertions assume that event inputs are synchronous to `clk` and that `ev_ret_id` always names an existing context. They also assume that a data return refers to a context the upstream memory system actually parked. They place no limit on how many events come at once, so the stimulus drives any mix of them, including events during a flush. The stimulus changes `ready_mask` only at its own negative-edge drive points and never leaves it all zero for long in the directed part. Events are held for one cycle each, which matches the single-cycle strobe behaviour the held-event queue is built for.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  // cause codes, value order equals priority position + 1
  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_SYNC = 3'd1,
    C_MISS = 3'd2,
    C_HINT = 3'd3,
    C_LPWR = 3'd4,
    C_TMO  = 3'd5,
    C_RET  = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    S_RUN   = 2'd0,
    S_FLUSH = 2'd1,
    S_IDLE  = 2'd2
  } sw_state_e;
endpackage

// File: rtl/tsw_evt_arb.sv
module tsw_evt_arb
  import tsw_pkg::*;
#(
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accum,
  input  logic           ev_sync,
  input  logic           ev_miss,
  input  logic           ev_hint,
  input  logic           ev_lpwr,
  input  logic           ev_tmo,
  input  logic           ev_ret,
  input  logic [IDW-1:0] ret_id,
  output cause_e         cause,
  output logic [IDW-1:0] cause_rid
);
  localparam int NEV = 6;

  logic [NEV-1:0] in_v;
  logic [NEV-1:0] all_v;
  logic [NEV-1:0] pend_q, pend_n;
  logic [IDW-1:0] pid_q, pid_n;
  logic           pid_en;

  always_comb begin
    in_v  = {ev_ret, ev_tmo, ev_lpwr, ev_hint, ev_miss, ev_sync};
    all_v = pend_q | in_v;
  end

  // lowest index wins
  always_comb begin
    cause = C_NONE;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (all_v[i]) cause = cause_e'(3'(i + 1));
    end
  end

  always_comb begin
    pend_n    = accum ? all_v : '0;
    pid_en    = accum && ev_ret;
    pid_n     = ret_id;
    cause_rid = ev_ret ? ret_id : pid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pid_q <= '0;
    else if (pid_en) pid_q <= pid_n;
  end

  assert_sync_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |-> cause == C_SYNC);
endmodule

// File: rtl/tsw_rr_pick.sv
module tsw_rr_pick #(
  parameter int NCTX = 4,
  parameter int IDW  = 2
) (
  input  logic [NCTX-1:0] elig,
  input  logic [IDW-1:0]  base,
  input  logic            incl_base,
  output logic            found,
  output logic [IDW-1:0]  idx
);
  // descending scan so the nearest successor is written last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCTX; i >= 1; i--) begin
      int k;
      k = (int'(base) + i) % NCTX;
      if (elig[k] && (i != NCTX || incl_base)) begin
        found = 1'b1;
        idx   = IDW'(k);
      end
    end
  end
endmodule

// File: rtl/tsw_ctx_pc.sv
module tsw_ctx_pc #(
  parameter int NCTX   = 4,
  parameter int PC_W   = 32,
  parameter int IDW    = 2,
  parameter int STRIDE = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDW-1:0]  widx,
  input  logic [PC_W-1:0] wdata,
  input  logic [IDW-1:0]  ridx,
  output logic [PC_W-1:0] rdata
);
  logic [PC_W-1:0] rd_v [NCTX];

  for (genvar g = 0; g < NCTX; g++) begin : g_slot
    logic [PC_W-1:0] q;
    logic            en;
    always_comb en = we && (widx == IDW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= PC_W'(g * STRIDE);
      else if (en) q <= wdata;
    end
    assign rd_v[g] = q;
  end

  always_comb rdata = rd_v[ridx];
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter  int NCTX      = 4,
  parameter  int PC_W      = 32,
  parameter  int FLUSH_CYC = 3,
  parameter  int TIMEOUT   = 20,
  parameter  int STRIDE    = 4096,
  localparam int IDW       = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] ready_mask,
  input  logic            ev_miss,
  input  logic            ev_sync,
  input  logic            ev_hint,
  input  logic            ev_lpwr,
  input  logic            ev_ret,
  input  logic [IDW-1:0]  ev_ret_id,
  input  logic [PC_W-1:0] cur_pc,
  output logic            flush,
  output logic            busy,
  output logic            idle,
  output logic [IDW-1:0]  active_id,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  localparam int CW = $clog2(FLUSH_CYC + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  sw_state_e       st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [TW-1:0]   tmr_q, tmr_n;
  logic [IDW-1:0]  act_q, act_n;
  logic [IDW-1:0]  tgt_q, tgt_n;
  logic            none_q, none_n;
  logic [NCTX-1:0] blk_q, blk_n;
  logic            flush_q, flush_n;
  logic            redir_q, redir_n;
  logic [PC_W-1:0] rpc_q, rpc_n;
  logic            rpc_en;

  logic [NCTX-1:0] ret_mask, blk_eff, elig;
  logic            tmo, blocking, ret_ok, sw, to_idle;
  cause_e          cause;
  logic [IDW-1:0]  cause_rid;
  logic            rr_found, id_found;
  logic [IDW-1:0]  rr_idx, id_idx;
  logic            save_we;
  logic [IDW-1:0]  rd_idx;
  logic [PC_W-1:0] rd_pc;

  always_comb begin
    ret_mask = ev_ret ? (NCTX'(1) << ev_ret_id) : '0;
    blk_eff  = blk_q & ~ret_mask;
    elig     = ready_mask & ~blk_eff;
    tmo      = (st_q == S_RUN) && (tmr_q == TW'(TIMEOUT - 1));
  end

  tsw_evt_arb #(.IDW(IDW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .accum    (st_q == S_FLUSH),
    .ev_sync  (ev_sync),
    .ev_miss  (ev_miss),
    .ev_hint  (ev_hint),
    .ev_lpwr  (ev_lpwr),
    .ev_tmo   (tmo),
    .ev_ret   (ev_ret),
    .ret_id   (ev_ret_id),
    .cause    (cause),
    .cause_rid(cause_rid)
  );

  tsw_rr_pick #(.NCTX(NCTX), .IDW(IDW)) u_pick_run (
    .elig     (elig),
    .base     (act_q),
    .incl_base(1'b0),
    .found    (rr_found),
    .idx      (rr_idx)
  );

  tsw_rr_pick #(.NCTX(NCTX), .IDW(IDW)) u_pick_idle (
    .elig     (elig),
    .base     (act_q),
    .incl_base(1'b1),
    .found    (id_found),
    .idx      (id_idx)
  );

  always_comb begin
    blocking = (cause == C_SYNC) || (cause == C_MISS);
    ret_ok   = (cause == C_RET) && (cause_rid != act_q) && elig[cause_rid];
    if (cause == C_RET) begin
      sw      = ret_ok;
      to_idle = 1'b0;
    end else begin
      sw      = rr_found || blocking;
      to_idle = !rr_found;
    end
  end

  always_comb rd_idx = (st_q == S_FLUSH) ? tgt_q : id_idx;

  tsw_ctx_pc #(.NCTX(NCTX), .PC_W(PC_W), .IDW(IDW), .STRIDE(STRIDE)) u_ctx (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (save_we),
    .widx (act_q),
    .wdata(cur_pc),
    .ridx (rd_idx),
    .rdata(rd_pc)
  );

  // next-state
  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    tmr_n   = tmr_q;
    act_n   = act_q;
    tgt_n   = tgt_q;
    none_n  = none_q;
    blk_n   = blk_eff;
    flush_n = 1'b0;
    redir_n = 1'b0;
    rpc_n   = rd_pc;
    rpc_en  = 1'b0;
    save_we = 1'b0;
    unique case (st_q)
      S_RUN: begin
        if (cause != C_NONE) begin
          tmr_n = '0;
          if (blocking) blk_n = blk_eff | (NCTX'(1) << act_q);
          if (sw) begin
            st_n    = S_FLUSH;
            cnt_n   = CW'(FLUSH_CYC - 1);
            flush_n = 1'b1;
            save_we = 1'b1;
            tgt_n   = (cause == C_RET) ? cause_rid : rr_idx;
            none_n  = to_idle;
          end
        end else begin
          tmr_n = tmr_q + TW'(1);
        end
      end
      S_FLUSH: begin
        if (cnt_q == '0) begin
          if (none_q) begin
            st_n = S_IDLE;
          end else begin
            st_n    = S_RUN;
            act_n   = tgt_q;
            redir_n = 1'b1;
            rpc_en  = 1'b1;
            tmr_n   = '0;
          end
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
      S_IDLE: begin
        if (id_found) begin
          st_n    = S_RUN;
          act_n   = id_idx;
          redir_n = 1'b1;
          rpc_en  = 1'b1;
          tmr_n   = '0;
        end
      end
      default: st_n = S_RUN;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_RUN;
      cnt_q   <= '0;
      tmr_q   <= '0;
      act_q   <= '0;
      tgt_q   <= '0;
      none_q  <= 1'b0;
      blk_q   <= '0;
      flush_q <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      tmr_q   <= tmr_n;
      act_q   <= act_n;
      tgt_q   <= tgt_n;
      none_q  <= none_n;
      blk_q   <= blk_n;
      flush_q <= flush_n;
      redir_q <= redir_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rpc_q <= '0;
    else if (rpc_en) rpc_q <= rpc_n;
  end

  always_comb begin
    flush       = flush_q;
    busy        = (st_q == S_FLUSH);
    idle        = (st_q == S_IDLE);
    active_id   = act_q;
    redir_valid = redir_q;
    redir_pc    = rpc_q;
  end

  assert_flush_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> busy);
  assert_redir_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!busy && !idle));
  assert_single_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  assert_owner_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush) |-> $stable(active_id));
  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(TIMEOUT));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!flush && !redir_valid));
  assert_pick_eligible_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rr_found |-> (elig[rr_idx] && rr_idx != act_q));
  assert_blocked_not_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_n && !to_idle && cause != C_RET |-> !blk_n[tgt_n]);
endmodule

// File: tb/sim_tsw_ctrl.sv
module sim_tsw_ctrl;
  localparam int  N      = 4;
  localparam int  FC     = 3;
  localparam int  TO     = 20;
  localparam int  STR    = 4096;
  localparam time PERIOD = 10;

  localparam int RUN = 0, FL = 1, IDL = 2;

  logic        clk, rst_n;
  logic [3:0]  ready_mask;
  logic        ev_miss, ev_sync, ev_hint, ev_lpwr, ev_ret;
  logic [1:0]  ev_ret_id;
  logic [31:0] cur_pc;
  logic        flush, busy, idle, redir_valid;
  logic [1:0]  active_id;
  logic [31:0] redir_pc;

  int n_chk, n_fail;
  bit done;

  tsw_ctrl #(.NCTX(N), .PC_W(32), .FLUSH_CYC(FC), .TIMEOUT(TO), .STRIDE(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .ready_mask(ready_mask),
    .ev_miss(ev_miss), .ev_sync(ev_sync), .ev_hint(ev_hint), .ev_lpwr(ev_lpwr),
    .ev_ret(ev_ret), .ev_ret_id(ev_ret_id), .cur_pc(cur_pc),
    .flush(flush), .busy(busy), .idle(idle), .active_id(active_id),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  // behavioural reference state
  int          m_st, m_cnt, m_tmr, m_act, m_tgt, m_pid;
  bit          m_none, m_flush, m_redir;
  bit          m_blk [N];
  bit          m_pend [6];
  logic [31:0] m_slot [N];
  logic [31:0] m_rpc;

  task automatic m_reset();
    m_st = RUN; m_cnt = 0; m_tmr = 0; m_act = 0; m_tgt = 0; m_pid = 0;
    m_none = 0; m_flush = 0; m_redir = 0; m_rpc = 0;
    for (int i = 0; i < N; i++) begin
      m_blk[i] = 0;
      m_slot[i] = 32'(i * STR);
    end
    for (int i = 0; i < 6; i++) m_pend[i] = 0;
  endtask

  task automatic m_step();
    bit elig [N];
    bit ev [6];
    bit nb [N];
    int cause, rid, tg;
    bit found, blocking, sw;
    for (int i = 0; i < N; i++) begin
      nb[i] = m_blk[i] && !(ev_ret && int'(ev_ret_id) == i);
      elig[i] = ready_mask[i] && !nb[i];
    end
    ev[0] = ev_sync; ev[1] = ev_miss; ev[2] = ev_hint; ev[3] = ev_lpwr;
    ev[4] = (m_st == RUN) && (m_tmr == TO - 1); ev[5] = ev_ret;
    cause = -1;
    for (int i = 0; i < 6; i++) if (cause < 0 && (ev[i] || m_pend[i])) cause = i;
    rid = ev_ret ? int'(ev_ret_id) : m_pid;
    m_flush = 0; m_redir = 0;
    if (m_st == RUN) begin
      if (cause >= 0) begin
        m_tmr = 0;
        blocking = (cause <= 1);
        if (blocking) nb[m_act] = 1;
        found = 0; tg = 0;
        for (int i = 1; i < N; i++)
          if (!found && elig[(m_act + i) % N]) begin found = 1; tg = (m_act + i) % N; end
        if (cause == 5) begin
          sw = (rid != m_act) && elig[rid];
          tg = rid; found = 1;
        end else sw = found || blocking;
        if (sw) begin
          m_slot[m_act] = cur_pc;
          m_st = FL; m_cnt = FC - 1; m_flush = 1; m_tgt = tg; m_none = !found;
        end
      end else m_tmr++;
      for (int i = 0; i < 6; i++) m_pend[i] = 0;
    end else if (m_st == FL) begin
      for (int i = 0; i < 6; i++) m_pend[i] = m_pend[i] || ev[i];
      if (ev_ret) m_pid = int'(ev_ret_id);
      if (m_cnt == 0) begin
        if (m_none) m_st = IDL;
        else begin
          m_st = RUN; m_act = m_tgt; m_redir = 1; m_rpc = m_slot[m_tgt]; m_tmr = 0;
        end
      end else m_cnt--;
    end else begin
      for (int i = 0; i < 6; i++) m_pend[i] = 0;
      found = 0; tg = 0;
      for (int i = 1; i <= N; i++)
        if (!found && elig[(m_act + i) % N]) begin found = 1; tg = (m_act + i) % N; end
      if (found) begin
        m_st = RUN; m_act = tg; m_redir = 1; m_rpc = m_slot[tg]; m_tmr = 0;
      end
    end
    for (int i = 0; i < N; i++) m_blk[i] = nb[i];
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // lock-step comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 active_id", 32'(active_id), 32'(m_act));
      chk("R2 flush", 32'(flush), 32'(m_flush));
      chk("R8 busy", 32'(busy), 32'(m_st == FL));
      chk("R9 idle", 32'(idle), 32'(m_st == IDL));
      chk("R2 redir_valid", 32'(redir_valid), 32'(m_redir));
      if (redir_valid) chk("R10 redir_pc", redir_pc, m_rpc);
    end
  end

  always @(posedge clk) cur_pc <= cur_pc + 32'h4;

  task automatic pulse(input int which, input int rid);
    ev_ret_id = 2'(rid);
    if (which == 0) ev_sync = 1;
    if (which == 1) ev_miss = 1;
    if (which == 2) ev_hint = 1;
    if (which == 3) ev_lpwr = 1;
    if (which == 5) ev_ret = 1;
    @(negedge clk);
    ev_sync = 0; ev_miss = 0; ev_hint = 0; ev_lpwr = 0; ev_ret = 0;
  endtask

  task automatic wait_redir(input int lim);
    for (int i = 0; i < lim && !redir_valid; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    report();
  end

  initial begin
    logic [15:0] lf;
    n_chk = 0; n_fail = 0; done = 0;
    m_reset();
    rst_n = 0; ready_mask = 4'b1111; cur_pc = 32'h8000_0000;
    ev_miss = 0; ev_sync = 0; ev_hint = 0; ev_lpwr = 0; ev_ret = 0; ev_ret_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 active", 32'(active_id), 0);
    chk("R1 quiet", 32'({flush, busy, idle, redir_valid}), 0);

    pulse(1, 0);                                   // miss on ctx0
    chk("R2 flush pulse", 32'({flush, busy}), 32'b11);
    wait_redir(10);
    chk("R2 new owner", 32'(active_id), 1);
    chk("R1 slot reset pc", redir_pc, 32'(STR));

    pulse(2, 0); wait_redir(10);
    chk("R6 hint target", 32'(active_id), 2);
    pulse(3, 0); wait_redir(10);
    chk("R6 lowpower target", 32'(active_id), 3);
    pulse(2, 0); wait_redir(10);
    chk("R3 blocked ctx0 skipped", 32'(active_id), 1);

    pulse(5, 0); wait_redir(10);
    chk("R4 return switches to ctx0", 32'(active_id), 0);

    ev_hint = 1; pulse(1, 0);                      // miss+hint together
    wait_redir(10);
    chk("R7 miss wins", 32'(active_id), 1);
    pulse(2, 0); wait_redir(10); pulse(2, 0); wait_redir(10);
    pulse(2, 0); wait_redir(10);
    chk("R7 ctx0 stayed blocked", 32'(active_id), 1);

    pulse(1, 0);                                   // miss on ctx1
    pulse(2, 0);                                   // hint during flush
    wait_redir(10);
    chk("R8 first target", 32'(active_id), 2);
    @(negedge clk);
    chk("R8 held hint flushes", 32'(flush), 1);
    wait_redir(10);
    chk("R8 second target", 32'(active_id), 3);

    @(negedge clk); wait_redir(TO + 10);
    chk("R5 timeout target", 32'(active_id), 2);
    @(negedge clk); wait_redir(TO + 10);
    chk("R5 old ctx still eligible", 32'(active_id), 3);

    ready_mask = 4'b1011;
    pulse(2, 0);
    chk("R9 keep running no flush", 32'({flush, 2'(active_id)}), 3);
    pulse(5, 1); wait_redir(10);
    chk("R4 return to ctx1", 32'(active_id), 1);
    pulse(2, 0); wait_redir(10);
    chk("R11 masked ctx2 skipped", 32'(active_id), 3);

    pulse(1, 0); wait_redir(10);
    chk("R3 miss on ctx3", 32'(active_id), 1);
    pulse(1, 0);
    for (int i = 0; i < 10 && !idle; i++) @(negedge clk);
    chk("R9 idle", 32'(idle), 1);
    pulse(5, 3);
    chk("R9 resume without flush", 32'({flush, idle, 2'(active_id)}), 3);

    // mixed stimulus phase
    lf = 16'hACE1;
    ready_mask = 4'b1111;
    for (int c = 0; c < 3000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ev_sync = (lf[3:0] == 4'h1);
      ev_miss = (lf[7:4] == 4'h2);
      ev_hint = (lf[11:8] == 4'h3);
      ev_lpwr = (lf[15:12] == 4'h4);
      ev_ret  = lf[2] && lf[9];
      ev_ret_id = lf[6:5];
      if (c % 97 == 0) ready_mask = lf[3:0] | 4'b0100;
      @(negedge clk);
    end
    ev_sync = 0; ev_miss = 0; ev_hint = 0; ev_lpwr = 0; ev_ret = 0;
    repeat (5) @(negedge clk);
    done = 1;
    report();
  end
endmodule